// File: doc/BRIEF.md
# Global Bypass Disposition Control Register

This block holds one 32-bit control word for an address translation unit and uses it to decide the fate of each incoming transaction while translation is globally switched off. Software reaches the word over a plain register bus (address, write enable, write data, read enable, read data). A write only changes the word when its top bit, the commit flag, is set. Writes without the flag are dropped. The commit completes at once, so the flag is never stored and never reads back as 1.

On the transaction side, a translation-enable level and a request strobe are decoded in the same cycle into one of three outcomes. If translation is on, the outcome is translate. If it is off, a single stored block bit picks between abort and untranslated pass-through. A change to the word affects transactions from the cycle after the write.

Top module: `xlate_bypass_ctrl`

## Requirements
- R1: After reset the control word reads as 0x00001000, with the block bit (bit 20) at 0.
- R2: A write to offset 0x44 with bit 31 at 0 is discarded, and the word keeps its previous value.
- R3: A write to offset 0x44 with bit 31 at 1 stores the write data with bit 31 cleared. Bit 31 therefore never reads back as 1.
- R4: A read strobe at offset 0x44 returns the stored word on `rd_data` in the cycle after the strobe. A read strobe at any other offset returns 0. `rd_data` holds its value while no read strobe is given.
- R5: A write to any offset other than 0x44 leaves the word unchanged, even when bit 31 is set.
- R6: While `xlate_en` is 1, every request gets `resp_kind` 2'b00 (translate), whatever the stored word holds.
- R7: While `xlate_en` is 0 and stored bit 20 is 1, every request gets `resp_kind` 2'b10 (abort).
- R8: While `xlate_en` is 0 and stored bit 20 is 0, every request gets `resp_kind` 2'b01 (pass through untranslated).
- R9: `resp_valid` equals `req_valid` in the same cycle, and `resp_kind` is decoded combinationally. A committing write accepted at a clock edge first changes the outcome just after that edge, never before it.
- R10: Reset is synchronous and active-low. It restores 0x00001000 even when a committing write is presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W (8) | Byte offset of the register access |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | DATA_W (32) | Write data |
| reg_rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W (32) | Registered read data, valid the cycle after the read strobe |
| xlate_en | input | 1 | Global translation enable |
| req_valid | input | 1 | Incoming transaction request |
| resp_valid | output | 1 | Disposition valid |
| resp_kind | output | 2 | Disposition: 00 translate, 01 pass through, 10 abort |

## Verification
The disposition is driven with all three combinations that matter:
- translation on, with the block bit both set and clear, which shows the word is ignored;
- translation off with the block bit clear;
- translation off with the block bit set.

Each combination yields a different outcome code. Writes are presented as pairs that differ only in the commit flag, and as pairs that differ only in the offset. This separates the commit rule from the address decode. A committing write is sampled against a request in the same cycle, before and after its clock edge, which pins the one-cycle effect. A write that coincides with reset shows that reset takes priority.

// File: rtl/xbc_pkg.sv
// Package: shared encodings for the bypass disposition control block.
// Assumes a single 32-bit control word; the field positions are parameters of the top.
package xbc_pkg;
    typedef enum logic [1:0] {
        DISP_TRANSLATE = 2'b00,
        DISP_BYPASS    = 2'b01,
        DISP_ABORT     = 2'b10
    } disp_e;
endpackage

// File: rtl/xbc_addr_decode.sv
// Module: xbc_addr_decode
// Turns the bus strobes into "write hits the word" and "read hits the word" qualifiers.
// Assumes full-width offset compare; any other offset is a miss.
module xbc_addr_decode #(
    parameter int          ADDR_W = 8,
    parameter logic [ADDR_W-1:0] OFFSET = 8'h44
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic              wr_hit,
    output logic              rd_hit
);
    logic match;

    // Compare the access offset with the word's offset and qualify the strobes.
    always_comb begin
        match  = (addr == OFFSET);
        wr_hit = wr_en && match;
        rd_hit = rd_en && match;
    end
endmodule

// File: rtl/xbc_word_store.sv
// Module: xbc_word_store
// Holds the control word and applies the commit-flag write rule.
// Assumes the commit completes in one cycle, so the flag position is never stored.
module xbc_word_store #(
    parameter int              DATA_W     = 32,
    parameter int              COMMIT_POS = 31,
    parameter logic [DATA_W-1:0] RESET_VAL = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] word_q
);
    localparam logic [DATA_W-1:0] COMMIT_MASK = DATA_W'(1) << COMMIT_POS;

    logic commit;

    // A write counts only when it hits the word and carries the commit flag.
    always_comb begin
        commit = wr_hit && wr_data[COMMIT_POS];
    end

    // Store the committed data with the flag cleared; reset takes priority over any write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= RESET_VAL;
        end else if (commit) begin
            word_q <= wr_data & ~COMMIT_MASK;
        end
    end
endmodule

// File: rtl/xbc_readback.sv
// Module: xbc_readback
// Registers read data one cycle after a read strobe: the word on a hit, zero on a miss.
// Assumes read data holds its value between strobes.
module xbc_readback #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] word_q,
    output logic [DATA_W-1:0] rd_data
);
    // Capture the read result on each strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_hit ? word_q : '0;
        end
    end
endmodule

// File: rtl/xbc_disposition.sv
// Module: xbc_disposition
// Decides translate, pass-through or abort for each request, combinationally.
// Assumes the block bit comes from a register, so no loop is formed.
module xbc_disposition
    import xbc_pkg::*;
(
    input  logic  xlate_en,
    input  logic  block_bit,
    input  logic  req_valid,
    output logic  resp_valid,
    output disp_e resp_kind
);
    // Pick the outcome from the enable level first, then from the stored block bit.
    always_comb begin
        resp_valid = req_valid;
        if (xlate_en) begin
            resp_kind = DISP_TRANSLATE;
        end else if (block_bit) begin
            resp_kind = DISP_ABORT;
        end else begin
            resp_kind = DISP_BYPASS;
        end
    end
endmodule

// File: rtl/xlate_bypass_ctrl.sv
// Module: xlate_bypass_ctrl (top)
// Control word that sets the fate of transactions while translation is globally off.
// Assumes a single-cycle register bus and a same-cycle request/disposition handshake.
module xlate_bypass_ctrl #(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] OFFSET     = 8'h44,
    parameter int                BLOCK_POS  = 20,
    parameter int                COMMIT_POS = 31,
    parameter logic [DATA_W-1:0] RESET_VAL  = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic              reg_rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              xlate_en,
    input  logic              req_valid,
    output logic              resp_valid,
    output logic [1:0]        resp_kind
);
    import xbc_pkg::*;

    logic              wr_hit;
    logic              rd_hit;
    logic [DATA_W-1:0] word_q;
    disp_e             kind;

    xbc_addr_decode #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_dec (
        .addr   (reg_addr),
        .wr_en  (reg_wr_en),
        .rd_en  (reg_rd_en),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    xbc_word_store #(.DATA_W(DATA_W), .COMMIT_POS(COMMIT_POS), .RESET_VAL(RESET_VAL)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wr_data (reg_wr_data),
        .word_q  (word_q)
    );

    xbc_readback #(.DATA_W(DATA_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (reg_rd_en),
        .rd_hit  (rd_hit),
        .word_q  (word_q),
        .rd_data (rd_data)
    );

    xbc_disposition u_disp (
        .xlate_en   (xlate_en),
        .block_bit  (word_q[BLOCK_POS]),
        .req_valid  (req_valid),
        .resp_valid (resp_valid),
        .resp_kind  (kind)
    );

    // Present the enumerated outcome as a plain vector at the port.
    always_comb begin
        resp_kind = kind;
    end
endmodule

// File: rtl/xbc_checker.sv
// Module: xbc_checker
// Temporal checks on the bypass control block, bound into every instance of the top.
// Assumes it sees the stored word through the bind connection.
module xbc_checker #(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] OFFSET     = 8'h44,
    parameter int                BLOCK_POS  = 20,
    parameter int                COMMIT_POS = 31,
    parameter logic [DATA_W-1:0] RESET_VAL  = 32'h0000_1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr_en,
    input logic [DATA_W-1:0] reg_wr_data,
    input logic              reg_rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              xlate_en,
    input logic              req_valid,
    input logic              resp_valid,
    input logic [1:0]        resp_kind,
    input logic [DATA_W-1:0] word_q
);
    localparam logic [DATA_W-1:0] KEEP_MASK = ~(DATA_W'(1) << COMMIT_POS);

    // R10: reset restores the reset word whatever else is presented.
    assert_reset_value_R10: assert property (@(posedge clk)
        !rst_n |=> word_q == RESET_VAL);

    // R2: an uncommitted write at the word's offset leaves it untouched.
    assert_no_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en && reg_addr == OFFSET && !reg_wr_data[COMMIT_POS] |=> $stable(word_q));

    // R3: a committing write stores the data without the flag.
    assert_commit_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en && reg_addr == OFFSET && reg_wr_data[COMMIT_POS]
        |=> word_q == ($past(reg_wr_data) & KEEP_MASK));

    // R3: the flag never reads back as 1.
    assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[COMMIT_POS]);

    // R4: a read strobe at another offset returns zero.
    assert_miss_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en && reg_addr != OFFSET |=> rd_data == '0);

    // R5: a write elsewhere does not touch the word.
    assert_miss_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_addr == OFFSET) |=> $stable(word_q));

    // R6: translation on means translate.
    assert_translate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xlate_en && req_valid |-> resp_kind == 2'b00);

    // R7: translation off with the block bit set means abort.
    assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !xlate_en && req_valid && word_q[BLOCK_POS] |-> resp_kind == 2'b10);

    // R8: translation off with the block bit clear means pass through.
    assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !xlate_en && req_valid && !word_q[BLOCK_POS] |-> resp_kind == 2'b01);

    // R9: the response strobe tracks the request strobe.
    assert_resp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid == req_valid);
endmodule

bind xlate_bypass_ctrl xbc_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(OFFSET),
    .BLOCK_POS(BLOCK_POS), .COMMIT_POS(COMMIT_POS), .RESET_VAL(RESET_VAL)
) u_xbc_checker (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en), .rd_data(rd_data),
    .xlate_en(xlate_en), .req_valid(req_valid), .resp_valid(resp_valid),
    .resp_kind(resp_kind), .word_q(word_q)
);

// File: tb/test_xlate_bypass_ctrl.sv
// Directed bench for xlate_bypass_ctrl: one task per scenario, each checking its own results.
module test_xlate_bypass_ctrl;
    localparam logic [1:0] K_XLATE = 2'b00;
    localparam logic [1:0] K_PASS  = 2'b01;
    localparam logic [1:0] K_ABORT = 2'b10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic        reg_rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        xlate_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        resp_valid;
    logic [1:0]  resp_kind;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    xlate_bypass_ctrl i_xlate_bypass_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en), .rd_data(rd_data),
        .xlate_en(xlate_en), .req_valid(req_valid), .resp_valid(resp_valid),
        .resp_kind(resp_kind)
    );

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd_en = 1'b1;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic probe(input string req, input logic en, input logic [1:0] exp);
        @(negedge clk);
        xlate_en = en; req_valid = 1'b1;
        #1;
        check32(req, {31'd0, resp_valid}, 32'd1);
        check32(req, {30'd0, resp_kind}, {30'd0, exp});
        req_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        reg_read(8'h44, d);
        check32("R1 reset word", d, 32'h0000_1000);
        probe("R8 pass after reset", 1'b0, K_PASS);
        probe("R6 translate after reset", 1'b1, K_XLATE);
    endtask

    task automatic t_uncommitted_write();
        logic [31:0] d;
        reg_write(8'h44, 32'h0010_0000);
        reg_read(8'h44, d);
        check32("R2 uncommitted write dropped", d, 32'h0000_1000);
        probe("R2 block bit not set by dropped write", 1'b0, K_PASS);
    endtask

    task automatic t_committed_write();
        logic [31:0] d;
        reg_write(8'h44, 32'h8010_1234);
        reg_read(8'h44, d);
        check32("R3 committed write stored, flag cleared", d, 32'h0010_1234);
        probe("R7 abort when off and blocked", 1'b0, K_ABORT);
        probe("R6 translate ignores block bit", 1'b1, K_XLATE);
    endtask

    task automatic t_other_offsets();
        logic [31:0] d;
        reg_write(8'h40, 32'h8000_0000);
        reg_write(8'h45, 32'h8000_1000);
        reg_read(8'h44, d);
        check32("R5 writes elsewhere ignored", d, 32'h0010_1234);
        probe("R5 outcome unchanged", 1'b0, K_ABORT);
        reg_read(8'h40, d);
        check32("R4 miss read 0x40 is zero", d, 32'h0);
        reg_read(8'h48, d);
        check32("R4 miss read 0x48 is zero", d, 32'h0);
        @(negedge clk);
        reg_addr = 8'h44;
        @(negedge clk);
        check32("R4 data held without strobe", rd_data, 32'h0);
    endtask

    task automatic t_write_timing();
        @(negedge clk);
        xlate_en = 1'b0; req_valid = 1'b1;
        reg_addr = 8'h44; reg_wr_data = 32'h8000_1000; reg_wr_en = 1'b1;
        #1;
        check32("R9 old outcome before edge", {30'd0, resp_kind}, {30'd0, K_ABORT});
        @(negedge clk);
        reg_wr_en = 1'b0;
        check32("R9 new outcome after edge", {30'd0, resp_kind}, {30'd0, K_PASS});
        check32("R9 resp_valid follows req", {31'd0, resp_valid}, 32'd1);
        req_valid = 1'b0;
        #1;
        check32("R9 resp_valid drops with req", {31'd0, resp_valid}, 32'd0);
    endtask

    task automatic t_reset_priority();
        logic [31:0] d;
        reg_write(8'h44, 32'h8010_0000);
        @(negedge clk);
        rst_n = 1'b0;
        reg_addr = 8'h44; reg_wr_data = 32'h8010_5555; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; rst_n = 1'b1;
        reg_read(8'h44, d);
        check32("R10 reset beats write", d, 32'h0000_1000);
        probe("R10 pass after reset", 1'b0, K_PASS);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_uncommitted_write();
        t_committed_write();
        t_other_offsets();
        t_write_timing();
        t_reset_priority();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule